// File: doc/BRIEF.md
# Self-Timed Byte-Write Memory Controller

This block is a clocked model of the control logic in a small byte-wide nonvolatile memory holding 2048 bytes. A fast system clock samples three active-low strobes (chip select, output enable, write enable), an 11-bit address and an 8-bit data bus. From these it decodes the read, write and idle modes. It latches the address and data of a write and then runs a self-timed programming interval whose length is a parameter.

While the programming interval runs, software finds out when it has finished by polling. A read of the address being programmed returns the inverse of the new bit 7 until the write lands. After that, all eight bits read true. The bidirectional bus is split into an input, an output and a drive-enable for tri-state modelling. A busy flag is brought out for observation. Each strobe, address and data input passes through two flops before the block uses it, so outputs follow the pins with a two-cycle delay.

Top module: `bytewrite_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `data_oe` is 0.
- R2: `data_oe` is 1 only while `cs_n`=0, `oe_n`=0 and `we_n`=1, two cycles after the pins. `data_out` then shows the byte at `addr`. With `cs_n`=1, `oe_n`=1 or `we_n`=0, `data_oe` is 0.
- R3: A write is only entered while `cs_n`=0, `we_n`=0 and `oe_n`=1. If `oe_n` is held low, or drops low before the terminating strobe rises, no write happens and `busy` stays 0.
- R4: The address is captured when the write condition is entered, at the later of the `cs_n`/`we_n` falling edges. Later address changes in the same write have no effect.
- R5: The data is captured at the earlier of the `cs_n`/`we_n` rising edges. That edge raises `busy` for exactly `WRITE_CYCLES` clock cycles.
- R6: When `busy` falls, the captured byte is stored at the captured address, and reads return all eight bits true.
- R7: While `busy` is 1, a read of the captured address returns the inverse of the captured bit 7 on bit 7 and zeros on bits 6..0.
- R8: While `busy` is 1, reads of any other address return the stored byte.
- R9: Write attempts made while `busy` is 1 are ignored. They change no byte and do not lengthen the busy interval.
- R10: All 2048 addresses, 0x000 through 0x7FF, hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| data_in | input | 8 | Data bus, inbound half |
| data_out | output | 8 | Data bus, outbound half |
| data_oe | output | 1 | Drive enable for the data bus |
| busy | output | 1 | Self-timed write in progress |

## Verification
The hardest state to reach is a second write issued while the first is still programming, combined with polling reads. The stimulus starts a write and then, inside the busy window, performs a full strobe sequence to another address. It later reads that address back and counts the busy cycles to show that nothing was stored and nothing restarted. The latch-point rules are checked by changing the address and data while the strobes are low. Only the address present at the later falling edge and the data present at the earlier rising edge must survive, in both strobe orders.

// File: rtl/bytewrite_ctrl.sv
module bytewrite_ctrl #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int WRITE_CYCLES = 500000,
  localparam int DEPTH = 1 << AW,
  localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          busy
);

  logic [1:0]    cs_q, oe_q, we_q;
  logic [AW-1:0] a_q1, a_s;
  logic [DW-1:0] d_q1, d_s;
  logic          wr_q, armed, busy_r;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] mem [DEPTH];

  wire cs_s    = cs_q[1];
  wire oe_s    = oe_q[1];
  wire we_s    = we_q[1];
  wire wr_cond = !cs_s && !we_s && oe_s;
  wire enter   = wr_cond && !wr_q && !busy_r;
  wire start   = armed && !wr_cond && oe_s;
  wire done    = busy_r && (cnt == '0);
  wire rd      = !cs_s && !oe_s && we_s;
  wire poll    = busy_r && (a_s == wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 2'b11;
      oe_q    <= 2'b11;
      we_q    <= 2'b11;
      a_q1    <= '0;
      a_s     <= '0;
      d_q1    <= '0;
      d_s     <= '0;
      wr_q    <= 1'b0;
      armed   <= 1'b0;
      busy_r  <= 1'b0;
      cnt     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      oe_q <= {oe_q[0], oe_n};
      we_q <= {we_q[0], we_n};
      a_q1 <= addr;
      a_s  <= a_q1;
      d_q1 <= data_in;
      d_s  <= d_q1;
      wr_q <= wr_cond;

      if (enter) begin
        armed   <= 1'b1;
        wr_addr <= a_s;
      end else if (!wr_cond) begin
        armed <= 1'b0;
      end

      if (wr_cond && (armed || enter))
        wr_data <= d_s;

      if (start) begin
        busy_r <= 1'b1;
        cnt    <= CW'(WRITE_CYCLES - 1);
      end else if (done) begin
        busy_r <= 1'b0;
      end else if (busy_r) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done)
      mem[wr_addr] <= wr_data;
  end

  assign data_oe  = rd;
  assign busy     = busy_r;
  assign data_out = poll ? {~wr_data[DW-1], {(DW-1){1'b0}}} : mem[a_s];

endmodule

// File: rtl/bytewrite_ctrl_chk.sv
module bytewrite_ctrl_chk #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          busy,
  input logic          data_oe,
  input logic          armed,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] mem_at_wr
);

  logic [1:0] cyc;
  int         busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= '0;
      busy_len <= 0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 1'b1;
      busy_len <= busy ? busy_len + 1 : 0;
    end
  end

  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(cs_n, 2)) |-> !data_oe);

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WRITE_CYCLES);

  // R6
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mem_at_wr == wr_data);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

bind bytewrite_ctrl bytewrite_ctrl_chk #(
  .AW(AW), .DW(DW), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .data_oe(data_oe),
  .armed(armed), .wr_addr(wr_addr), .wr_data(wr_data), .mem_at_wr(mem[wr_addr])
);

// File: tb/tb_bytewrite_ctrl.sv
module tb_bytewrite_ctrl;
  localparam int WC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe, busy;

  int total = 0, bad = 0, busy_cycles = 0;
  bit finished = 0;

  bytewrite_ctrl #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d, output logic oe);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    step(4);
    d = data_out; oe = data_oe;
    idle();
    step(2);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) step(1);
  endtask

  task automatic write_we(input logic [10:0] a, input logic [7:0] d);
    cs_n = 1'b0; oe_n = 1'b1; addr = a; data_in = ~d;
    step(3);
    we_n = 1'b0;
    step(4);
    addr = ~a;
    step(2);
    data_in = d;
    step(3);
    we_n = 1'b1;
    step(1);
    cs_n = 1'b1; addr = a; data_in = 8'h00;
    step(4);
  endtask

  task automatic write_ce(input logic [10:0] a, input logic [7:0] d);
    we_n = 1'b0; oe_n = 1'b1; addr = ~a; data_in = ~d;
    step(3);
    addr = a;
    cs_n = 1'b0;
    step(4);
    addr = ~a;
    step(2);
    data_in = d;
    step(3);
    cs_n = 1'b1;
    step(1);
    we_n = 1'b1; addr = a; data_in = 8'h00;
    step(4);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(data_oe == 1'b0, "R1 data_oe", data_oe, 0);
  endtask

  task automatic t_we_write_and_poll();
    logic [7:0] d; logic oe;
    busy_cycles = 0;
    write_we(11'h6DC, 8'h3C);
    chk(busy == 1'b1, "R5 busy after edge", busy, 1);
    wait_idle();
    chk(busy_cycles == WC, "R5 busy length", busy_cycles, WC);
    write_we(11'h123, 8'hA5);
    rd(11'h123, d, oe);
    chk(oe == 1'b1, "R2 read drive", oe, 1);
    chk(d == 8'h00, "R7 poll inverted bit7", d, 8'h00);
    rd(11'h6DC, d, oe);
    chk(d == 8'h3C, "R8 other addr during busy", d, 8'h3C);
    wait_idle();
    rd(11'h123, d, oe);
    chk(d == 8'hA5, "R6 true data after done", d, 8'hA5);
    rd(11'h6DC, d, oe);
    chk(d == 8'h3C, "R4 later address change ignored", d, 8'h3C);
  endtask

  task automatic t_ce_write();
    logic [7:0] d; logic oe;
    write_ce(11'h000, 8'h5A);
    chk(busy == 1'b1, "R5 cs-terminated start", busy, 1);
    rd(11'h000, d, oe);
    chk(d == 8'h80, "R7 poll inverted bit7", d, 8'h80);
    wait_idle();
    rd(11'h000, d, oe);
    chk(d == 8'h5A, "R4 cs-controlled address/data", d, 8'h5A);
  endtask

  task automatic t_extremes();
    logic [7:0] d; logic oe;
    write_we(11'h7FF, 8'hC3);
    wait_idle();
    rd(11'h7FF, d, oe);
    chk(d == 8'hC3, "R10 top address", d, 8'hC3);
    rd(11'h000, d, oe);
    chk(d == 8'h5A, "R10 bottom address intact", d, 8'h5A);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d; logic oe;
    write_we(11'h010, 8'h11);
    wait_idle();
    busy_cycles = 0;
    write_we(11'h200, 8'h77);
    write_we(11'h010, 8'hEE);
    wait_idle();
    step(4);
    chk(busy_cycles == WC, "R9 no busy extension", busy_cycles, WC);
    chk(busy == 1'b0, "R9 no restart", busy, 0);
    rd(11'h010, d, oe);
    chk(d == 8'h11, "R9 busy write ignored", d, 8'h11);
    rd(11'h200, d, oe);
    chk(d == 8'h77, "R6 first write stored", d, 8'h77);
  endtask

  task automatic t_inhibit();
    logic [7:0] d; logic oe;
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 11'h010; data_in = 8'h99;
    step(4);
    chk(data_oe == 1'b0, "R2 no drive with we low", data_oe, 0);
    idle();
    step(4);
    chk(busy == 1'b0, "R3 oe low inhibits", busy, 0);
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    step(4);
    oe_n = 1'b0;
    step(3);
    we_n = 1'b1;
    step(1);
    idle();
    step(4);
    chk(busy == 1'b0, "R3 oe drop aborts", busy, 0);
    rd(11'h010, d, oe);
    chk(d == 8'h11, "R3 byte unchanged", d, 8'h11);
    cs_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    step(4);
    chk(data_oe == 1'b0, "R2 cs high releases", data_oe, 0);
    cs_n = 1'b0; oe_n = 1'b1;
    step(4);
    chk(data_oe == 1'b0, "R2 oe high releases", data_oe, 0);
    idle();
    step(2);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_we_write_and_poll();
    t_ce_write();
    t_extremes();
    t_busy_ignore();
    t_inhibit();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule